// File: doc/BRIEF.md
# Table Pointer and Flash Write Buffer

This block gives a processor byte-wide table access to a program flash. It keeps a 22-bit byte pointer, built from three byte-wide registers that software loads through a small register-write port. It also keeps an 8-bit data latch and a bank of eight holding registers. A command port accepts four operations:

- table read
- table write
- long write
- erase

A table read sends the pointer to a memory read port and places the returned byte in the latch. A table write copies the latch into the holding register chosen by the pointer's three low bits. A long write hands the flash controller an 8-byte-aligned address and the contents of all eight holding registers. An erase hands it a 64-byte-aligned address.

Table reads and table writes carry a pointer-update mode. Increment and decrement act only on the low 21 bits of the pointer and wrap inside them. Bit 21 is never touched by them, and it selects the identification and configuration space in place of program memory.

The command port and the memory read-request port use a valid/ready handshake. The command port accepts a command only while the block is idle (`cmd_ready` high). A command held on `cmd_valid` while the block is busy is not taken and has no effect. The memory read request stays valid, with a stable address, until the memory raises `mem_rd_ready`. The memory response has no back-pressure: a single `mem_rsp_valid` pulse is accepted while the block waits for it. The flash request is held until a one-cycle `fl_ack`.

Top module: `table_access_unit`

## Requirements
- R1: After reset the pointer and the latch read 0, every holding register holds 8'hFF, `busy` is 0 and `cmd_ready` is 1.
- R2: A register write with select 0, 1 or 2 loads pointer bits 7:0, 15:8 or 21:16. With select 2 only the six low data bits are kept. Select 3 loads the latch. The write takes effect at the next clock edge. It is dropped when the block is busy, and it is dropped when `cmd_valid` is high in the same cycle.
- R3: A table read requests the address equal to the pointer, except in pre-increment mode (mode 3), where it requests the incremented pointer. Command op codes are 0 read, 1 table write, 2 long write and 3 erase.
- R4: After a table read or table write, the pointer depends on the mode. Mode 0 leaves it unchanged. Mode 1 gives the accessed address plus one. Mode 2 gives the accessed address minus one. Mode 3 gives the accessed address. The update lands in the cycle the access completes.
- R5: Increment and decrement change only bits 20:0, modulo 2^21. Bit 21 keeps its value. For example, 0x1FFFFF+1 gives 0x000000 and 0x200000-1 gives 0x3FFFFF.
- R6: When `mem_rsp_valid` arrives after an accepted read request, the response byte is loaded into the latch at that edge, and `busy` falls at the same edge.
- R7: A table write completes in the cycle it is accepted, without raising `busy`. It stores the latch into holding register N, where N is bits 2:0 of the accessed address.
- R8: A long write raises `fl_req_valid` with `fl_req_erase`=0 and an address equal to the pointer with bits 2:0 cleared. `fl_wdata` carries holding register N in bits 8N+7:8N. After `fl_ack`, every holding register is 8'hFF and the pointer is unchanged.
- R9: An erase raises `fl_req_valid` with `fl_req_erase`=1 and an address equal to the pointer with bits 5:0 cleared. It leaves the holding registers and the pointer unchanged.
- R10: `busy` is high, and `cmd_ready` low, from the cycle after a read, long write or erase is accepted until the edge at which it completes. Commands presented in that interval are ignored.
- R11: `mem_rd_valid` stays high with a stable `mem_rd_addr` until the cycle in which `mem_rd_ready` is seen, and falls after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | 0 pointer low, 1 pointer high, 2 pointer upper, 3 latch |
| reg_wr_data | input | 8 | Register write data |
| cur_ptr | output | 22 | Current pointer value |
| data_latch | output | 8 | Current latch value |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high together with cmd_valid |
| cmd_op | input | 2 | 0 read, 1 table write, 2 long write, 3 erase |
| cmd_mode | input | 2 | 0 keep, 1 post-increment, 2 post-decrement, 3 pre-increment |
| busy | output | 1 | Command in progress |
| mem_rd_valid | output | 1 | Memory read request valid |
| mem_rd_ready | input | 1 | Memory read request accepted |
| mem_rd_addr | output | 22 | Memory read byte address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | 8 | Memory read data |
| fl_req_valid | output | 1 | Flash long-write or erase request |
| fl_req_erase | output | 1 | 1 erase, 0 long write |
| fl_req_addr | output | 22 | Block-aligned flash address |
| fl_wdata | output | 64 | Holding registers, register N in bits 8N+7:8N |
| fl_ack | input | 1 | Flash controller completion pulse |

## Verification
The bench builds the block with its default parameters: a 22-bit pointer, byte-wide data, eight holding registers and a 64-byte erase granule. With these values the wrap at 0x1FFFFF and the configuration bit are each one step away. The three-bit holding index and the three- and six-bit alignment masks are exercised exactly as the flash sees them. The 64-bit `fl_wdata` makes every holding slot visible at the ports, so table writes, the clear after a long write and the untouched bank after an erase are all checked there.

// File: rtl/tau_pkg.sv
package tau_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_LWRITE = 2'd2,
    OP_ERASE  = 2'd3
  } tau_op_e;

  typedef enum logic [1:0] {
    MD_KEEP     = 2'd0,
    MD_POST_INC = 2'd1,
    MD_POST_DEC = 2'd2,
    MD_PRE_INC  = 2'd3
  } tau_mode_e;

  typedef enum logic [1:0] {
    SEL_LOW   = 2'd0,
    SEL_HIGH  = 2'd1,
    SEL_UPPER = 2'd2,
    SEL_LATCH = 2'd3
  } tau_sel_e;

endpackage

// File: rtl/tau_ptr_regs.sv
module tau_ptr_regs
  import tau_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_val,
  input  logic              lat_ld_en,
  input  logic [DATA_W-1:0] lat_ld_data,
  output logic [ADDR_W-1:0] ptr,
  output logic [DATA_W-1:0] latch
);
  localparam int UPPER_W = ADDR_W - 2 * DATA_W;

  logic [ADDR_W-1:0] ptr_q;
  logic [DATA_W-1:0] lat_q;

  // pointer: sequencer update has priority over bus writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (upd_en) begin
      ptr_q <= upd_val;
    end else if (wr_en) begin
      case (tau_sel_e'(wr_sel))
        SEL_LOW:   ptr_q[DATA_W-1:0]          <= wr_data;
        SEL_HIGH:  ptr_q[2*DATA_W-1:DATA_W]   <= wr_data;
        SEL_UPPER: ptr_q[ADDR_W-1:2*DATA_W]   <= wr_data[UPPER_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (lat_ld_en) begin
      lat_q <= lat_ld_data;
    end else if (wr_en && tau_sel_e'(wr_sel) == SEL_LATCH) begin
      lat_q <= wr_data;
    end
  end

  assign ptr   = ptr_q;
  assign latch = lat_q;
endmodule

// File: rtl/tau_hold_bank.sv
module tau_hold_bank #(
  parameter int DATA_W = 8,
  parameter int HOLD_N = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(HOLD_N)-1:0] wr_idx,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     clr,
  output logic [HOLD_N*DATA_W-1:0] bank
);
  localparam int IDX_W = $clog2(HOLD_N);

  for (genvar g = 0; g < HOLD_N; g++) begin : g_slot
    logic [DATA_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
        slot_q <= '1;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        slot_q <= wr_data;
      end
    end
    assign bank[g*DATA_W +: DATA_W] = slot_q;
  end
endmodule

// File: rtl/tau_seq.sv
module tau_seq
  import tau_pkg::*;
#(
  parameter int ADDR_W    = 22,
  parameter int HOLD_N    = 8,
  parameter int ERASE_BLK = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_op,
  input  logic [1:0]                cmd_mode,
  output logic                      cmd_ready,
  output logic                      busy,
  input  logic [ADDR_W-1:0]         ptr,
  input  logic                      reg_wr_en,
  output logic                      reg_ok,
  output logic                      mem_rd_valid,
  input  logic                      mem_rd_ready,
  output logic [ADDR_W-1:0]         mem_rd_addr,
  input  logic                      mem_rsp_valid,
  output logic                      ptr_upd_en,
  output logic [ADDR_W-1:0]         ptr_upd_val,
  output logic                      lat_ld_en,
  output logic                      hold_wr_en,
  output logic [$clog2(HOLD_N)-1:0] hold_wr_idx,
  output logic                      hold_clr,
  output logic                      fl_req_valid,
  output logic                      fl_req_erase,
  output logic [ADDR_W-1:0]         fl_req_addr,
  input  logic                      fl_ack
);
  localparam int IDX_W   = $clog2(HOLD_N);
  localparam int ERASE_W = $clog2(ERASE_BLK);
  localparam int LOW_W   = ADDR_W - 1;

  typedef enum logic [1:0] {S_IDLE, S_RD_REQ, S_RD_WAIT, S_FLASH} st_e;

  st_e               st_q;
  logic [ADDR_W-1:0] acc_q;
  tau_mode_e         mode_q;
  logic              erase_q;

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a, input logic down);
    logic [LOW_W-1:0] lo;
    lo = down ? a[LOW_W-1:0] - LOW_W'(1) : a[LOW_W-1:0] + LOW_W'(1);
    return {a[ADDR_W-1], lo};
  endfunction

  function automatic logic [ADDR_W-1:0] after_access(input logic [ADDR_W-1:0] a, input tau_mode_e m);
    case (m)
      MD_POST_INC: return step(a, 1'b0);
      MD_POST_DEC: return step(a, 1'b1);
      default:     return a;
    endcase
  endfunction

  tau_op_e           op_c;
  tau_mode_e         mode_c;
  logic              accept;
  logic [ADDR_W-1:0] pre_addr;
  logic [ADDR_W-1:0] lw_addr;
  logic [ADDR_W-1:0] er_addr;

  assign op_c     = tau_op_e'(cmd_op);
  assign mode_c   = tau_mode_e'(cmd_mode);
  assign accept   = cmd_valid && st_q == S_IDLE;
  assign pre_addr = (mode_c == MD_PRE_INC) ? step(ptr, 1'b0) : ptr;
  assign lw_addr  = {ptr[ADDR_W-1:IDX_W], IDX_W'(0)};
  assign er_addr  = {ptr[ADDR_W-1:ERASE_W], ERASE_W'(0)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      acc_q   <= '0;
      mode_q  <= MD_KEEP;
      erase_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (accept) begin
          mode_q <= mode_c;
          case (op_c)
            OP_READ:   begin acc_q <= pre_addr; st_q <= S_RD_REQ; end
            OP_LWRITE: begin acc_q <= lw_addr; erase_q <= 1'b0; st_q <= S_FLASH; end
            OP_ERASE:  begin acc_q <= er_addr; erase_q <= 1'b1; st_q <= S_FLASH; end
            default:   ;
          endcase
        end
        S_RD_REQ:  if (mem_rd_ready)  st_q <= S_RD_WAIT;
        S_RD_WAIT: if (mem_rsp_valid) st_q <= S_IDLE;
        S_FLASH:   if (fl_ack)        st_q <= S_IDLE;
        default:   st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_ready    = (st_q == S_IDLE);
    busy         = (st_q != S_IDLE);
    reg_ok       = reg_wr_en && st_q == S_IDLE && !cmd_valid;
    mem_rd_valid = (st_q == S_RD_REQ);
    mem_rd_addr  = acc_q;
    fl_req_valid = (st_q == S_FLASH);
    fl_req_erase = erase_q;
    fl_req_addr  = acc_q;
    hold_wr_en   = accept && op_c == OP_WRITE;
    hold_wr_idx  = pre_addr[IDX_W-1:0];
    hold_clr     = (st_q == S_FLASH) && fl_ack && !erase_q;
    lat_ld_en    = (st_q == S_RD_WAIT) && mem_rsp_valid;
    ptr_upd_en   = hold_wr_en || lat_ld_en;
    ptr_upd_val  = lat_ld_en ? after_access(acc_q, mode_q) : after_access(pre_addr, mode_c);
  end
endmodule

// File: rtl/table_access_unit.sv
module table_access_unit #(
  parameter int ADDR_W    = 22,
  parameter int DATA_W    = 8,
  parameter int HOLD_N    = 8,
  parameter int ERASE_BLK = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr_en,
  input  logic [1:0]               reg_wr_sel,
  input  logic [DATA_W-1:0]        reg_wr_data,
  output logic [ADDR_W-1:0]        cur_ptr,
  output logic [DATA_W-1:0]        data_latch,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic [1:0]               cmd_op,
  input  logic [1:0]               cmd_mode,
  output logic                     busy,
  output logic                     mem_rd_valid,
  input  logic                     mem_rd_ready,
  output logic [ADDR_W-1:0]        mem_rd_addr,
  input  logic                     mem_rsp_valid,
  input  logic [DATA_W-1:0]        mem_rsp_data,
  output logic                     fl_req_valid,
  output logic                     fl_req_erase,
  output logic [ADDR_W-1:0]        fl_req_addr,
  output logic [HOLD_N*DATA_W-1:0] fl_wdata,
  input  logic                     fl_ack
);
  localparam int IDX_W = $clog2(HOLD_N);

  logic              reg_ok;
  logic              ptr_upd_en;
  logic [ADDR_W-1:0] ptr_upd_val;
  logic              lat_ld_en;
  logic              hold_wr_en;
  logic [IDX_W-1:0]  hold_wr_idx;
  logic              hold_clr;

  tau_seq #(.ADDR_W(ADDR_W), .HOLD_N(HOLD_N), .ERASE_BLK(ERASE_BLK)) u_seq (
    .clk, .rst_n,
    .cmd_valid, .cmd_op, .cmd_mode, .cmd_ready, .busy,
    .ptr(cur_ptr), .reg_wr_en, .reg_ok,
    .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rsp_valid,
    .ptr_upd_en, .ptr_upd_val, .lat_ld_en,
    .hold_wr_en, .hold_wr_idx, .hold_clr,
    .fl_req_valid, .fl_req_erase, .fl_req_addr, .fl_ack
  );

  tau_ptr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk, .rst_n,
    .wr_en(reg_ok), .wr_sel(reg_wr_sel), .wr_data(reg_wr_data),
    .upd_en(ptr_upd_en), .upd_val(ptr_upd_val),
    .lat_ld_en, .lat_ld_data(mem_rsp_data),
    .ptr(cur_ptr), .latch(data_latch)
  );

  tau_hold_bank #(.DATA_W(DATA_W), .HOLD_N(HOLD_N)) u_hold (
    .clk, .rst_n,
    .wr_en(hold_wr_en), .wr_idx(hold_wr_idx), .wr_data(data_latch),
    .clr(hold_clr), .bank(fl_wdata)
  );
endmodule

// File: rtl/tau_checker.sv
module tau_checker #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 8,
  parameter int HOLD_N = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     reg_wr_en,
  input logic [1:0]               reg_wr_sel,
  input logic [ADDR_W-1:0]        cur_ptr,
  input logic                     cmd_valid,
  input logic                     cmd_ready,
  input logic [1:0]               cmd_op,
  input logic                     busy,
  input logic                     mem_rd_valid,
  input logic                     mem_rd_ready,
  input logic [ADDR_W-1:0]        mem_rd_addr,
  input logic                     fl_req_valid,
  input logic                     fl_req_erase,
  input logic [ADDR_W-1:0]        fl_req_addr,
  input logic [HOLD_N*DATA_W-1:0] fl_wdata,
  input logic                     fl_ack
);
  // R11
  rd_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R11
  rd_req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> busy);

  // R10
  read_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 2'd0 |=> busy && mem_rd_valid);

  // R8
  lwrite_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid && !fl_req_erase |-> fl_req_addr[2:0] == 3'd0);

  // R9
  erase_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid && fl_req_erase |-> fl_req_addr[5:0] == 6'd0);

  // R8
  lwrite_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req_valid && fl_ack && !fl_req_erase |=> fl_wdata == '1);

  // R5
  cfg_bit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_wr_sel == 2'd2) |=> $stable(cur_ptr[ADDR_W-1]));
endmodule

bind table_access_unit tau_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD_N(HOLD_N)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
  .cur_ptr(cur_ptr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
  .busy(busy), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr(mem_rd_addr), .fl_req_valid(fl_req_valid), .fl_req_erase(fl_req_erase),
  .fl_req_addr(fl_req_addr), .fl_wdata(fl_wdata), .fl_ack(fl_ack)
);

// File: tb/table_access_unit_test.sv
`timescale 1ns/1ps
module table_access_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_sel = 2'd0;
  logic [7:0]  reg_wr_data = 8'd0;
  logic [21:0] cur_ptr;
  logic [7:0]  data_latch;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic [1:0]  cmd_mode = 2'd0;
  logic        busy;
  logic        mem_rd_valid;
  logic        mem_rd_ready = 1'b0;
  logic [21:0] mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [7:0]  mem_rsp_data = 8'd0;
  logic        fl_req_valid;
  logic        fl_req_erase;
  logic [21:0] fl_req_addr;
  logic [63:0] fl_wdata;
  logic        fl_ack = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  table_access_unit uut (
    .clk, .rst_n, .reg_wr_en, .reg_wr_sel, .reg_wr_data, .cur_ptr, .data_latch,
    .cmd_valid, .cmd_ready, .cmd_op, .cmd_mode, .busy,
    .mem_rd_valid, .mem_rd_ready, .mem_rd_addr, .mem_rsp_valid, .mem_rsp_data,
    .fl_req_valid, .fl_req_erase, .fl_req_addr, .fl_wdata, .fl_ack
  );

  function automatic logic [7:0] mbyte(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]} ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_reg(input logic [1:0] sel, input logic [7:0] d);
    reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic set_ptr(input logic [21:0] v);
    set_reg(2'd0, v[7:0]);
    set_reg(2'd1, v[15:8]);
    set_reg(2'd2, {2'b00, v[21:16]});
  endtask

  task automatic do_read(input string req, input logic [1:0] mode, input logic [21:0] exp_addr,
                         input logic [21:0] exp_ptr, input int stall);
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_mode = mode;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10", "busy after read accept", 64'(busy), 64'd1);
    chk("R10", "cmd_ready while busy", 64'(cmd_ready), 64'd0);
    chk("R3", "read request valid", 64'(mem_rd_valid), 64'd1);
    chk(req, "read address", 64'(mem_rd_addr), 64'(exp_addr));
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R11", "request held under back-pressure", 64'(mem_rd_valid), 64'd1);
      chk("R11", "address stable under back-pressure", 64'(mem_rd_addr), 64'(exp_addr));
    end
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    chk("R11", "request dropped after ready", 64'(mem_rd_valid), 64'd0);
    chk("R10", "busy while awaiting data", 64'(busy), 64'd1);
    mem_rsp_valid = 1'b1; mem_rsp_data = mbyte(exp_addr);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R6", "latch after response", 64'(data_latch), 64'(mbyte(exp_addr)));
    chk("R6", "busy after response", 64'(busy), 64'd0);
    chk(req == "R5" ? "R5" : "R4", "pointer after read", 64'(cur_ptr), 64'(exp_ptr));
  endtask

  task automatic do_twrite(input logic [1:0] mode, input logic [21:0] exp_ptr);
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_mode = mode;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R7", "busy after table write", 64'(busy), 64'd0);
    chk("R4", "pointer after table write", 64'(cur_ptr), 64'(exp_ptr));
  endtask

  task automatic do_flash(input string req, input bit is_erase, input logic [21:0] exp_addr,
                          input logic [63:0] exp_wdata, input int delay, input logic [21:0] exp_ptr);
    cmd_valid = 1'b1; cmd_op = is_erase ? 2'd3 : 2'd2; cmd_mode = 2'd1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10", "busy after flash accept", 64'(busy), 64'd1);
    chk(req, "flash request valid", 64'(fl_req_valid), 64'd1);
    chk(req, "flash erase flag", 64'(fl_req_erase), 64'(is_erase));
    chk(req, "flash address", 64'(fl_req_addr), 64'(exp_addr));
    chk(req, "flash data", fl_wdata, exp_wdata);
    for (int i = 0; i < delay; i++) begin
      @(negedge clk);
      chk(req, "flash request held", 64'(fl_req_valid), 64'd1);
    end
    fl_ack = 1'b1;
    @(negedge clk);
    fl_ack = 1'b0;
    chk("R10", "busy after ack", 64'(busy), 64'd0);
    chk(req, "flash request dropped", 64'(fl_req_valid), 64'd0);
    chk(req, "pointer after flash op", 64'(cur_ptr), 64'(exp_ptr));
    chk(req, "holding regs after flash op", fl_wdata, is_erase ? exp_wdata : 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_reset;
    chk("R1", "pointer reset", 64'(cur_ptr), 64'd0);
    chk("R1", "latch reset", 64'(data_latch), 64'd0);
    chk("R1", "holding regs reset", fl_wdata, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R1", "busy reset", 64'(busy), 64'd0);
    chk("R1", "cmd_ready reset", 64'(cmd_ready), 64'd1);
  endtask

  task automatic t_regs;
    set_reg(2'd0, 8'h56);
    set_reg(2'd1, 8'h34);
    set_reg(2'd2, 8'hD2);
    chk("R2", "pointer bytes with upper masked", 64'(cur_ptr), 64'h12_3456);
    set_reg(2'd3, 8'hA5);
    chk("R2", "latch write", 64'(data_latch), 64'hA5);
    chk("R2", "latch write leaves pointer", 64'(cur_ptr), 64'h12_3456);
  endtask

  task automatic t_read_modes;
    set_ptr(22'h000100);
    do_read("R3", 2'd0, 22'h000100, 22'h000100, 0);
    do_read("R3", 2'd1, 22'h000100, 22'h000101, 2);
    do_read("R3", 2'd2, 22'h000101, 22'h000100, 0);
    do_read("R3", 2'd3, 22'h000101, 22'h000101, 1);
  endtask

  task automatic t_wrap;
    set_ptr(22'h1FFFFF);
    do_read("R5", 2'd1, 22'h1FFFFF, 22'h000000, 0);
    set_ptr(22'h200000);
    do_read("R5", 2'd2, 22'h200000, 22'h3FFFFF, 0);
    do_read("R5", 2'd3, 22'h200000, 22'h200000, 0);
  endtask

  task automatic t_busy_ignore;
    set_ptr(22'h000040);
    // R2: write coinciding with a command is dropped
    cmd_valid = 1'b1; cmd_op = 2'd0; cmd_mode = 2'd0;
    reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = 8'h99;
    @(negedge clk);
    cmd_valid = 1'b0; reg_wr_en = 1'b0;
    chk("R2", "pointer after write beside command", 64'(cur_ptr), 64'h000040);
    // R10: command and register write while busy are ignored
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_mode = 2'd1;
    reg_wr_en = 1'b1; reg_wr_sel = 2'd0; reg_wr_data = 8'h77;
    @(negedge clk);
    cmd_valid = 1'b0; reg_wr_en = 1'b0;
    chk("R10", "pointer during busy", 64'(cur_ptr), 64'h000040);
    mem_rd_ready = 1'b1;
    @(negedge clk);
    mem_rd_ready = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_data = mbyte(22'h000040);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R2", "pointer after busy-time write", 64'(cur_ptr), 64'h000040);
    chk("R10", "holding regs after busy-time command", fl_wdata, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_table_writes;
    set_ptr(22'h000208);
    for (int i = 0; i < 8; i++) begin
      set_reg(2'd3, 8'(8'h10 + i));
      do_twrite(2'd1, 22'(22'h000208 + i + 1));
    end
    chk("R7", "slots filled by post-increment writes", fl_wdata, 64'h1716_1514_1312_1110);
    set_ptr(22'h00020D);
    do_flash("R8", 1'b0, 22'h000208, 64'h1716_1514_1312_1110, 2, 22'h00020D);
    set_ptr(22'h000300);
    set_reg(2'd3, 8'hC3);
    do_twrite(2'd3, 22'h000301);
    set_reg(2'd3, 8'h3C);
    do_twrite(2'd2, 22'h000300);
    set_reg(2'd3, 8'h99);
    do_twrite(2'd0, 22'h000300);
    chk("R7", "slot choice per mode", fl_wdata, 64'hFFFF_FFFF_FFFF_3C99);
    do_flash("R8", 1'b0, 22'h000300, 64'hFFFF_FFFF_FFFF_3C99, 0, 22'h000300);
  endtask

  task automatic t_erase;
    set_ptr(22'h2ABCDE);
    set_reg(2'd3, 8'h5E);
    do_twrite(2'd0, 22'h2ABCDE);
    do_flash("R9", 1'b1, 22'h2ABCC0, 64'hFF5E_FFFF_FFFF_FFFF, 3, 22'h2ABCDE);
    do_flash("R8", 1'b0, 22'h2ABCD8, 64'hFF5E_FFFF_FFFF_FFFF, 1, 22'h2ABCDE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_read_modes;
    t_wrap;
    t_busy_ignore;
    t_table_writes;
    t_erase;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule